// File: doc/BRIEF.md
# Graphics Aperture Plane Mapper

This block sits between the CPU side of a display controller and its four byte-wide display-memory planes. For each CPU byte access that falls inside the graphics aperture, it returns which plane the byte belongs to and the byte's offset within that plane. Addresses outside the aperture produce a miss, and no plane is selected for them.

Two placements are supported. In interleaved (chain-4) placement, successive bytes rotate through planes 0 to 3, and each plane keeps the byte at its own address with the two low bits cleared, so three of every four plane locations stay unused. In packed placement, successive bytes still rotate through the planes, but the plane offset is the window offset divided by four. The four planes then together hold the bytes exactly like one flat array. The aperture starts at A0000h. It spans 64KB by default and can be widened to 128KB (A0000h to BFFFFh) by a control bit.

The placement bit and the aperture bit are sampled together with the access strobe. A setting changed after an access has been issued only applies to later accesses. The result is registered and appears one clock after the strobe.

Top module: `aperture_plane_mapper`

## Requirements
- R1: While reset is held, and right after it, rsp_valid, rsp_we, rsp_hit and plane_en are all 0.
- R2: A strobe sampled at a rising edge produces rsp_valid = 1 in the following cycle only. A cycle with no strobe produces rsp_valid = 0 and plane_en = 0.
- R3: With win_128k = 0, the aperture is A0000h to AFFFFh inclusive. B0000h misses.
- R4: With win_128k = 1, the aperture is A0000h to BFFFFh inclusive. 9FFFFh and C0000h miss.
- R5: On a miss, rsp_hit = 0, plane_en = 0 and plane_off = 0.
- R6: With mode_packed = 0 (chain-4), and w = cpu_addr − A0000h, plane_en has only bit w[1:0] set (bit n selects plane n) and plane_off = w with bits 1:0 cleared.
- R7: With mode_packed = 1, plane_en has only bit w[1:0] set and plane_off = w >> 2. Bytes written at consecutive addresses fill the four planes so that plane (i mod 4), offset (i div 4) holds byte i.
- R8: mode_packed and win_128k are taken at the strobe edge. Changing them in the cycle after the strobe does not alter that access's result, and the new value applies from the next strobe.
- R9: rsp_we equals acc_we as sampled with the strobe, and is 0 when there is no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_stb | input | 1 | Access strobe, one cycle per access |
| acc_we | input | 1 | 1 for a write, 0 for a read |
| cpu_addr | input | 20 | CPU byte address |
| mode_packed | input | 1 | 1 selects packed placement, 0 selects chain-4 |
| win_128k | input | 1 | 1 widens the aperture to 128KB |
| rsp_valid | output | 1 | Result valid, one cycle after the strobe |
| rsp_we | output | 1 | Registered write flag |
| rsp_hit | output | 1 | Address fell inside the aperture |
| plane_en | output | 4 | One-hot plane enable, bit n for plane n |
| plane_off | output | 17 | Byte offset within the selected plane |

## Verification
Every result is due exactly one rising edge after the strobe is sampled. The bench drives the strobe, address and control bits on a falling edge and compares the outputs on the next falling edge. Each compare therefore sees precisely the registered result of that access. To check that the mode is taken at the strobe, the bench flips the placement bit on that same later falling edge, after the sampling edge has passed. It then confirms that the result still follows the old setting and that the next access follows the new one.

// File: rtl/aperture_plane_mapper.sv
module aperture_plane_mapper #(
  parameter int ADDR_W      = 20,
  parameter int OFF_W       = 17,
  parameter int NARROW_BITS = 16,
  parameter int WIDE_BITS   = 17,
  parameter logic [ADDR_W-1:0] BASE = 20'hA0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_stb,
  input  logic              acc_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              mode_packed,
  input  logic              win_128k,
  output logic              rsp_valid,
  output logic              rsp_we,
  output logic              rsp_hit,
  output logic [3:0]        plane_en,
  output logic [OFF_W-1:0]  plane_off
);

  logic [ADDR_W:0]   diff;
  logic [ADDR_W-1:0] win;
  logic              below, in_ap;
  logic [1:0]        sel;
  logic [OFF_W-1:0]  off_chain, off_packed;

  assign diff  = {1'b0, cpu_addr} - {1'b0, BASE};
  assign below = diff[ADDR_W];
  assign win   = diff[ADDR_W-1:0];
  assign in_ap = !below && (win_128k ? ((win >> WIDE_BITS) == '0)
                                     : ((win >> NARROW_BITS) == '0));
  assign sel        = win[1:0];
  assign off_chain  = {win[OFF_W-1:2], 2'b00};
  assign off_packed = win[OFF_W+1:2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_we    <= 1'b0;
      rsp_hit   <= 1'b0;
      plane_en  <= '0;
      plane_off <= '0;
    end else begin
      rsp_valid <= acc_stb;
      rsp_we    <= acc_stb && acc_we;
      rsp_hit   <= acc_stb && in_ap;
      plane_en  <= (acc_stb && in_ap) ? (4'b0001 << sel) : 4'b0000;
      if (acc_stb && in_ap)
        plane_off <= mode_packed ? off_packed : off_chain;
      else
        plane_off <= '0;
    end
  end

  // R2
  stb_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_stb |=> rsp_valid);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_stb |=> (!rsp_valid && plane_en == 4'b0000));

  // R5
  miss_no_plane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> (plane_en == 4'b0000 && plane_off == '0));

  // R6
  chain_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && !mode_packed) |=> (plane_off[1:0] == 2'b00));

  // R7
  hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> ($countones(plane_en) == 1 && rsp_valid));

  // R9
  we_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_we |-> rsp_valid);

endmodule

// File: tb/aperture_plane_mapper_test.sv
module aperture_plane_mapper_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_stb = 1'b0, acc_we = 1'b0;
  logic [19:0] cpu_addr = '0;
  logic        mode_packed = 1'b0, win_128k = 1'b0;
  logic        rsp_valid, rsp_we, rsp_hit;
  logic [3:0]  plane_en;
  logic [16:0] plane_off;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] planes [4][16];

  always #2.5 clk = ~clk;

  aperture_plane_mapper uut (
    .clk(clk), .rst_n(rst_n), .acc_stb(acc_stb), .acc_we(acc_we),
    .cpu_addr(cpu_addr), .mode_packed(mode_packed), .win_128k(win_128k),
    .rsp_valid(rsp_valid), .rsp_we(rsp_we), .rsp_hit(rsp_hit),
    .plane_en(plane_en), .plane_off(plane_off));

  // {win_128k, mode_packed, addr, exp_hit, exp_en, exp_off}
  localparam int NV = 12;
  localparam logic [43:0] VEC [NV] = '{
    {1'b0, 1'b0, 20'hA0000, 1'b1, 4'b0001, 17'h00000},
    {1'b0, 1'b0, 20'hA0007, 1'b1, 4'b1000, 17'h00004},
    {1'b0, 1'b1, 20'hA0007, 1'b1, 4'b1000, 17'h00001},
    {1'b0, 1'b1, 20'hA1235, 1'b1, 4'b0010, 17'h0048D},
    {1'b0, 1'b0, 20'hA1235, 1'b1, 4'b0010, 17'h01234},
    {1'b0, 1'b0, 20'hAFFFF, 1'b1, 4'b1000, 17'h0FFFC},
    {1'b0, 1'b0, 20'hB0000, 1'b0, 4'b0000, 17'h00000},
    {1'b1, 1'b0, 20'hB0000, 1'b1, 4'b0001, 17'h10000},
    {1'b1, 1'b1, 20'hBFFFE, 1'b1, 4'b0100, 17'h07FFF},
    {1'b1, 1'b0, 20'hC0000, 1'b0, 4'b0000, 17'h00000},
    {1'b1, 1'b1, 20'h9FFFF, 1'b0, 4'b0000, 17'h00000},
    {1'b0, 1'b1, 20'h00000, 1'b0, 4'b0000, 17'h00000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [19:0] a, input logic pk, input logic wd, input logic we);
    @(negedge clk);
    cpu_addr = a; mode_packed = pk; win_128k = wd; acc_we = we; acc_stb = 1'b1;
    @(negedge clk);
    acc_stb = 1'b0; acc_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid", 32'(rsp_valid), 0);
    check("R1 hit", 32'(rsp_hit), 0);
    check("R1 en", 32'(plane_en), 0);
    check("R1 we", 32'(rsp_we), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after release", 32'(rsp_valid), 0);

    for (int i = 0; i < NV; i++) begin
      logic [43:0] v;
      string tag;
      v = VEC[i];
      tag = !v[21] ? "R5/R3/R4" : (v[42] ? "R7/R3/R4" : "R6/R3/R4");
      issue(v[41:22], v[42], v[43], 1'b0);
      check({tag, " valid"}, 32'(rsp_valid), 1);
      check({tag, " hit"}, 32'(rsp_hit), 32'(v[21]));
      check({tag, " en"}, 32'(plane_en), 32'(v[20:17]));
      check({tag, " off"}, 32'(plane_off), 32'(v[16:0]));
    end

    // R2: idle cycle produces nothing
    @(negedge clk);
    check("R2 idle valid", 32'(rsp_valid), 0);
    check("R2 idle en", 32'(plane_en), 0);

    // R9: write flag follows strobe
    issue(20'hA0010, 1'b0, 1'b0, 1'b1);
    check("R9 we", 32'(rsp_we), 1);
    @(negedge clk);
    check("R9 we idle", 32'(rsp_we), 0);

    // R8: mode flipped after strobe edge does not affect that access
    @(negedge clk);
    cpu_addr = 20'hA0007; mode_packed = 1'b0; win_128k = 1'b0; acc_stb = 1'b1;
    @(negedge clk);
    acc_stb = 1'b0; mode_packed = 1'b1; win_128k = 1'b1;
    check("R8 old mode off", 32'(plane_off), 32'h4);
    @(negedge clk);
    cpu_addr = 20'hB0007; acc_stb = 1'b1;
    @(negedge clk);
    acc_stb = 1'b0;
    check("R8 new mode hit", 32'(rsp_hit), 1);
    check("R8 new mode off", 32'(plane_off), 32'h4001);

    // R7: packed bytes laid out as a flat array across the planes
    for (int p = 0; p < 4; p++)
      for (int k = 0; k < 16; k++) planes[p][k] = 8'hFF;
    for (int i = 0; i < 32; i++) begin
      issue(20'hA0000 + 20'(i), 1'b1, 1'b0, 1'b1);
      for (int p = 0; p < 4; p++)
        if (plane_en[p] && plane_off < 17'd16) planes[p][plane_off[3:0]] = 8'(i);
    end
    for (int i = 0; i < 32; i++)
      check("R7 flat layout", 32'(planes[i % 4][i / 4]), 32'(i));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule